// File: doc/BRIEF.md
# Secured Single-Wire Debug Monitor

This block is a debug monitor that a host reaches through one serial wire shared by both directions. The host sends 8N1 frames. The engine turns each received byte around and sends it back before it does anything else, so the host can confirm what arrived. It then runs a six-command set against a byte-wide memory port and a 16-bit stack-pointer input. The block drives the wire only while it is sending. The surrounding pad logic joins `pin_out`, `pin_oe` and `pin_in` into one physical pin.

After reset, the first six bytes the host sends are treated as a key. Each one is compared with a stored byte, which the engine fetches through the memory port from six consecutive addresses. If all six match, the monitor is unlocked and the engine holds the wire low for ten bit times to report success. If any byte differs, the monitor stays locked. Every command still runs while locked, but reads that fall in the protected window come back as zero. Writes are never blocked, and that includes the write that triggers a mass erase.

The bit time is `CLK_HZ / BAUD` clock cycles. The memory is external and must answer reads combinationally.

Top module: `mon_engine`

## Requirements
- R1: Frames sent by the engine hold the line idle high, then a low start bit, then eight data bits least significant first, then a high stop bit, each lasting `CLK_HZ/BAUD` clocks.
- R2: Every byte received from the host is sent back unchanged before the engine acts on it, including key bytes and operand bytes.
- R3: `pin_oe` is high only while the engine is sending a frame or a break. Otherwise `pin_oe` is 0 and `pin_out` is 1, which is also the state right after reset. The receiver does not sample the line while the engine is sending.
- R4: The first six bytes after reset are compared, in order, with memory bytes at `KEY_BASE`+0 through `KEY_BASE`+5 (default 0xFFF8 to 0xFFFD). All six must be equal to unlock.
- R5: On a full key match, right after the sixth echo, the engine drives the line low for ten bit times. On a mismatch it sends nothing.
- R6: While locked, any returned memory byte whose address lies in [`PROT_LO`, `PROT_HI`] (default 0xC000 to 0xFFFF) reads as 0x00, and bytes outside that window return their real value. Once unlocked, all bytes return their real value.
- R7: READ (opcode 0x4A, then address high byte, then address low byte) returns one byte from that address and sets the pointer to the address plus 1.
- R8: WRITE (0x49, address high, address low, data) produces exactly one single-cycle write of the data to that address, whether locked or not, and sets the pointer to the address plus 1.
- R9: IREAD (0x1A) returns the bytes at the pointer and at pointer+1, in that order, then advances the pointer by 2.
- R10: IWRITE (0x19, data) writes the data at the pointer, then advances the pointer by 1.
- R11: READSP (0x0C) returns `sp_in[15:8]` first and then `sp_in[7:0]`.
- R12: RUN (0x28) raises `run_pulse` for exactly one clock cycle after its echo.
- R13: A write to `ERASE_ADDR` (default 0xFE00) raises `erase_req` in the same cycle as that write, also while locked. Writes to any other address leave `erase_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Level seen on the shared serial wire |
| pin_out | output | 1 | Level the engine drives when enabled |
| pin_oe | output | 1 | Driver enable for the shared wire |
| mem_addr | output | 16 | Memory address for key fetch, reads and writes |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Single-cycle write strobe |
| erase_req | output | 1 | Mass-erase request, pulses with a write to the erase address |
| sp_in | input | 16 | Current stack pointer value |
| run_pulse | output | 1 | Single-cycle request to start the user program |

## Verification
The assertions assume that the host never starts a frame while the engine is still answering. Under that assumption, a receive event can never coincide with the engine's own transmission, and the controller never asks the transmitter to start while a frame is still in flight. The stimulus keeps to this rule: the host sends the next byte only after it has collected every echo and response byte and has seen the driver enable drop. The memory model answers reads in the same cycle. Its array aliases on the low address byte, so the test addresses are chosen so that they do not collide with the key bytes.

// File: rtl/mon_pkg.sv
package mon_pkg;

    typedef logic [7:0]  mon_byte_t;
    typedef logic [15:0] mon_addr_t;

    localparam mon_byte_t OP_READ   = 8'h4A;
    localparam mon_byte_t OP_WRITE  = 8'h49;
    localparam mon_byte_t OP_IREAD  = 8'h1A;
    localparam mon_byte_t OP_IWRITE = 8'h19;
    localparam mon_byte_t OP_READSP = 8'h0C;
    localparam mon_byte_t OP_RUN    = 8'h28;

    typedef enum logic [3:0] {
        ST_WAIT, ST_ECHO, ST_ECHO_WT, ST_ACT, ST_SEND,
        ST_SEND_WT, ST_WRITE, ST_BREAK, ST_BREAK_WT
    } mon_state_e;

    typedef enum logic [2:0] {
        PH_KEY, PH_OP, PH_AHI, PH_ALO, PH_DATA
    } mon_phase_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP
    } mon_rx_e;

    typedef struct packed {
        logic      brk;
        mon_byte_t data;
    } mon_txreq_t;

    function automatic logic in_window(mon_addr_t a, mon_addr_t lo, mon_addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic mon_byte_t hide_if(logic hide, mon_byte_t d);
        return hide ? 8'h00 : d;
    endfunction

endpackage

// File: rtl/mon_tx.sv
module mon_tx
    import mon_pkg::*;
#(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  mon_txreq_t req,
    output logic       line_out,
    output logic       line_oe,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(BIT_CYC);

    logic [CW-1:0] cnt;
    logic [3:0]    idx;
    logic [9:0]    sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '1;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                    idx  <= '0;
                    sh   <= req.brk ? 10'b0 : {1'b1, req.data, 1'b0};
                end
            end else if (cnt == CW'(BIT_CYC - 1)) begin
                cnt <= '0;
                sh  <= {1'b1, sh[9:1]};
                if (idx == 4'd9) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 4'd1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line_out = busy ? sh[0] : 1'b1;
    assign line_oe  = busy;

    // R3: the controller only asks for a frame when the line driver is free
    assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R1: every frame or break lasts exactly ten bit slots
    assert_frame_len_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(idx) == 4'd9);

endmodule

// File: rtl/mon_rx.sv
module mon_rx
    import mon_pkg::*;
#(
    parameter int BIT_CYC = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      line_in,
    output logic      valid,
    output mon_byte_t data
);
    localparam int CW   = $clog2(BIT_CYC);
    localparam int HALF = BIT_CYC / 2;

    mon_rx_e       st;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    mon_byte_t     sh;
    logic          s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            valid <= 1'b0;
            data  <= '0;
            s1    <= 1'b1;
            s2    <= 1'b1;
        end else begin
            s1    <= line_in;
            s2    <= s1;
            valid <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: if (!s2) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        idx <= '0;
                        st  <= s2 ? RX_IDLE : RX_BITS;
                    end else cnt <= cnt + 1'b1;
                    RX_BITS: if (cnt == CW'(BIT_CYC - 1)) begin
                        cnt <= '0;
                        sh  <= {s2, sh[7:1]};
                        if (idx == 3'd7) st <= RX_STOP;
                        else idx <= idx + 3'd1;
                    end else cnt <= cnt + 1'b1;
                    RX_STOP: if (cnt == CW'(BIT_CYC - 1)) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                        if (s2) begin
                            valid <= 1'b1;
                            data  <= sh;
                        end
                    end else cnt <= cnt + 1'b1;
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
    import mon_pkg::*;
#(
    parameter int        KEY_LEN    = 6,
    parameter mon_addr_t KEY_BASE   = 16'hFFF8,
    parameter mon_addr_t PROT_LO    = 16'hC000,
    parameter mon_addr_t PROT_HI    = 16'hFFFF,
    parameter mon_addr_t ERASE_ADDR = 16'hFE00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  mon_byte_t  rx_byte,
    input  logic       tx_done,
    input  mon_byte_t  mem_rdata,
    input  mon_addr_t  sp_in,
    output logic       tx_start,
    output mon_txreq_t tx_req,
    output mon_addr_t  mem_addr,
    output mon_byte_t  mem_wdata,
    output logic       mem_we,
    output logic       erase_req,
    output logic       run_pulse
);
    localparam int KW = $clog2(KEY_LEN);

    mon_state_e    st;
    mon_phase_e    ph;
    mon_byte_t     rxd, op, ahi, wdat, resp;
    mon_addr_t     cur, ptr, key_addr, rd_addr;
    logic [KW-1:0] kidx;
    logic          key_ok, unlocked, ridx, two;

    assign key_addr = KEY_BASE + mon_addr_t'(kidx);
    assign rd_addr  = cur + {15'b0, ridx};
    assign mem_addr = (ph == PH_KEY) ? key_addr : rd_addr;

    always_comb begin
        if (op == OP_READSP) resp = ridx ? sp_in[7:0] : sp_in[15:8];
        else resp = hide_if(!unlocked && in_window(rd_addr, PROT_LO, PROT_HI), mem_rdata);
    end

    assign tx_start    = (st == ST_ECHO) || (st == ST_SEND) || (st == ST_BREAK);
    assign tx_req.brk  = (st == ST_BREAK);
    assign tx_req.data = (st == ST_SEND) ? resp : rxd;
    assign mem_we      = (st == ST_WRITE);
    assign mem_wdata   = wdat;
    assign erase_req   = mem_we && (cur == ERASE_ADDR);
    assign run_pulse   = (st == ST_ACT) && (ph == PH_OP) && (rxd == OP_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_WAIT;
            ph       <= PH_KEY;
            rxd      <= '0;
            op       <= '0;
            ahi      <= '0;
            wdat     <= '0;
            cur      <= '0;
            ptr      <= '0;
            kidx     <= '0;
            key_ok   <= 1'b1;
            unlocked <= 1'b0;
            ridx     <= 1'b0;
            two      <= 1'b0;
        end else begin
            case (st)
                ST_WAIT: if (rx_valid) begin
                    rxd <= rx_byte;
                    st  <= ST_ECHO;
                    if (ph == PH_KEY) key_ok <= key_ok & (rx_byte == mem_rdata);
                end
                ST_ECHO:    st <= ST_ECHO_WT;
                ST_ECHO_WT: if (tx_done) st <= ST_ACT;
                ST_ACT: begin
                    st <= ST_WAIT;
                    case (ph)
                        PH_KEY: if (kidx == KW'(KEY_LEN - 1)) begin
                            unlocked <= key_ok;
                            ph       <= PH_OP;
                            if (key_ok) st <= ST_BREAK;
                        end else kidx <= kidx + 1'b1;
                        PH_OP: begin
                            op <= rxd;
                            case (rxd)
                                OP_READ, OP_WRITE: ph <= PH_AHI;
                                OP_IWRITE: begin
                                    cur <= ptr;
                                    ph  <= PH_DATA;
                                end
                                OP_IREAD: begin
                                    cur  <= ptr;
                                    ptr  <= ptr + 16'd2;
                                    two  <= 1'b1;
                                    ridx <= 1'b0;
                                    st   <= ST_SEND;
                                end
                                OP_READSP: begin
                                    two  <= 1'b1;
                                    ridx <= 1'b0;
                                    st   <= ST_SEND;
                                end
                                default: ;
                            endcase
                        end
                        PH_AHI: begin
                            ahi <= rxd;
                            ph  <= PH_ALO;
                        end
                        PH_ALO: begin
                            cur <= {ahi, rxd};
                            ptr <= {ahi, rxd} + 16'd1;
                            if (op == OP_READ) begin
                                two  <= 1'b0;
                                ridx <= 1'b0;
                                st   <= ST_SEND;
                                ph   <= PH_OP;
                            end else ph <= PH_DATA;
                        end
                        PH_DATA: begin
                            wdat <= rxd;
                            st   <= ST_WRITE;
                            ph   <= PH_OP;
                            if (op == OP_IWRITE) ptr <= ptr + 16'd1;
                        end
                        default: ph <= PH_OP;
                    endcase
                end
                ST_SEND:    st <= ST_SEND_WT;
                ST_SEND_WT: if (tx_done) begin
                    if (two && !ridx) begin
                        ridx <= 1'b1;
                        st   <= ST_SEND;
                    end else begin
                        ridx <= 1'b0;
                        st   <= ST_WAIT;
                    end
                end
                ST_WRITE:    st <= ST_WAIT;
                ST_BREAK:    st <= ST_BREAK_WT;
                ST_BREAK_WT: if (tx_done) st <= ST_WAIT;
                default:     st <= ST_WAIT;
            endcase
        end
    end

    // R12: the start request never lasts longer than one cycle
    assert_run_single_R12: assert property (@(posedge clk) disable iff (rst)
        run_pulse |=> !run_pulse);

    // R8: every write strobe is a single cycle
    assert_we_single_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R4: the lock decision changes only at the close of the key phase
    assert_lock_key_phase_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(unlocked) |-> $past(ph) == PH_KEY);

endmodule

// File: rtl/mon_engine.sv
module mon_engine
    import mon_pkg::*;
#(
    parameter int          CLK_HZ     = 9_830_400,
    parameter int          BAUD       = 9600,
    parameter int          KEY_LEN    = 6,
    parameter logic [15:0] KEY_BASE   = 16'hFFF8,
    parameter logic [15:0] PROT_LO    = 16'hC000,
    parameter logic [15:0] PROT_HI    = 16'hFFFF,
    parameter logic [15:0] ERASE_ADDR = 16'hFE00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_in,
    output logic        pin_out,
    output logic        pin_oe,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        erase_req,
    input  logic [15:0] sp_in,
    output logic        run_pulse
);
    localparam int BIT_CYC = CLK_HZ / BAUD;

    logic       rx_valid, tx_start, tx_busy, tx_done;
    mon_byte_t  rx_byte;
    mon_txreq_t tx_req;

    mon_rx #(.BIT_CYC(BIT_CYC)) rx_i (
        .clk(clk), .rst(rst), .en(!tx_busy), .line_in(pin_in),
        .valid(rx_valid), .data(rx_byte)
    );

    mon_tx #(.BIT_CYC(BIT_CYC)) tx_i (
        .clk(clk), .rst(rst), .start(tx_start), .req(tx_req),
        .line_out(pin_out), .line_oe(pin_oe), .busy(tx_busy), .done(tx_done)
    );

    mon_ctrl #(
        .KEY_LEN(KEY_LEN), .KEY_BASE(KEY_BASE), .PROT_LO(PROT_LO),
        .PROT_HI(PROT_HI), .ERASE_ADDR(ERASE_ADDR)
    ) ctrl_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_done(tx_done), .mem_rdata(mem_rdata), .sp_in(sp_in),
        .tx_start(tx_start), .tx_req(tx_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .erase_req(erase_req),
        .run_pulse(run_pulse)
    );

    // R3: nothing is received while the engine itself is sending
    assert_no_rx_in_tx_R3: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && tx_busy));

endmodule

// File: tb/mon_engine_tb_top.sv
module mon_engine_tb_top;
    localparam int BC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_line = 1'b1;
    logic        pad, pin_out, pin_oe, mem_we, erase_req, run_pulse;
    logic [15:0] mem_addr;
    logic [15:0] sp_in = 16'h12F0;
    logic [7:0]  mem_rdata, mem_wdata;
    logic [7:0]  mem [0:255];
    int          n_chk = 0, n_fail = 0, we_cnt = 0, erase_cnt = 0, run_cnt = 0;

    always #5 clk = ~clk;

    assign pad       = pin_oe ? pin_out : host_line;
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (!rst) begin
            if (mem_we)    we_cnt++;
            if (erase_req) erase_cnt++;
            if (run_pulse) run_cnt++;
        end
    end

    mon_engine #(.CLK_HZ(BC * 9600), .BAUD(9600)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pad), .pin_out(pin_out), .pin_oe(pin_oe),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .erase_req(erase_req), .sp_in(sp_in), .run_pulse(run_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        host_line = 1'b1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_send(input logic [7:0] b);
        @(negedge clk);
        host_line = 1'b0;
        repeat (BC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_line = b[i];
            repeat (BC) @(negedge clk);
        end
        host_line = 1'b1;
        repeat (BC / 2) @(negedge clk);
    endtask

    task automatic host_recv(output logic [7:0] b, output bit ok);
        int t = 0;
        ok = 1'b1;
        b  = 8'h00;
        while (pad !== 1'b0 && t < 40 * BC) begin
            @(negedge clk);
            t++;
        end
        if (t >= 40 * BC) begin
            ok = 1'b0;
            return;
        end
        repeat (BC / 2) @(negedge clk);
        if (pad !== 1'b0 || pin_oe !== 1'b1) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (BC) @(negedge clk);
            b[i] = pad;
        end
        repeat (BC) @(negedge clk);
        if (pad !== 1'b1) ok = 1'b0;
        while (pin_oe) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b);
        logic [7:0] e;
        bit ok;
        host_send(b);
        host_recv(e, ok);
        chk(ok && e == b, "R1 R2 echo frame", e, b);
    endtask

    task automatic get_resp(input logic [7:0] exp, input string req);
        logic [7:0] v;
        bit ok;
        host_recv(v, ok);
        chk(ok && v == exp, req, v, exp);
    endtask

    task automatic t_reset();
        chk(pin_oe == 1'b0 && pin_out == 1'b1, "R3 idle line after reset", {pin_oe, pin_out}, 2'b01);
        chk(mem_we == 1'b0 && run_pulse == 1'b0, "R12 no strobes after reset", {mem_we, run_pulse}, 0);
    endtask

    task automatic t_key(input logic [7:0] k [6], input bit expect_break);
        int t = 0, n = 0;
        for (int i = 0; i < 6; i++) xfer(k[i]);
        chk(pin_oe == 1'b0 && pin_out == 1'b1, "R3 driver released after echo", {pin_oe, pin_out}, 2'b01);
        if (expect_break) begin
            while (pad !== 1'b0 && t < 40 * BC) begin
                @(negedge clk);
                t++;
            end
            while (pad === 1'b0 && n < 20 * BC) begin
                @(negedge clk);
                n++;
            end
            chk(n >= 10 * BC - 2 && n <= 10 * BC + 2, "R4 R5 break after key match", n, 10 * BC);
        end else begin
            repeat (20 * BC) begin
                @(negedge clk);
                if (pad === 1'b0) n++;
            end
            chk(n == 0, "R5 no break on key mismatch", n, 0);
        end
    endtask

    task automatic cmd_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        xfer(8'h4A);
        xfer(a[15:8]);
        xfer(a[7:0]);
        get_resp(exp, req);
    endtask

    task automatic cmd_iread(input logic [7:0] e0, input logic [7:0] e1, input string req);
        xfer(8'h1A);
        get_resp(e0, req);
        get_resp(e1, req);
    endtask

    task automatic cmd_write(input logic [15:0] a, input logic [7:0] d, input bit erase_exp);
        int w0 = we_cnt, e0 = erase_cnt;
        xfer(8'h49);
        xfer(a[15:8]);
        xfer(a[7:0]);
        xfer(d);
        repeat (6) @(negedge clk);
        chk(we_cnt == w0 + 1, "R8 one write strobe", we_cnt - w0, 1);
        chk(mem[a[7:0]] == d, "R8 written data", mem[a[7:0]], d);
        chk(erase_cnt == e0 + int'(erase_exp), "R13 erase request", erase_cnt - e0, int'(erase_exp));
    endtask

    task automatic cmd_iwrite(input logic [7:0] at, input logic [7:0] d);
        int w0 = we_cnt;
        xfer(8'h19);
        xfer(d);
        repeat (6) @(negedge clk);
        chk(we_cnt == w0 + 1 && mem[at] == d, "R10 indexed write", mem[at], d);
    endtask

    task automatic t_locked();
        cmd_read(16'hC020, 8'h00, "R6 protected read hidden");
        cmd_iread(8'h00, 8'h00, "R6 R9 protected indexed read hidden");
        cmd_read(16'h0010, mem[8'h10], "R7 unprotected read");
        cmd_iread(mem[8'h11], mem[8'h12], "R9 pointer from read address");
        cmd_iread(mem[8'h13], mem[8'h14], "R9 pointer advanced by two");
        cmd_write(16'h0030, 8'hA5, 1'b0);
        cmd_iwrite(8'h31, 8'h66);
        cmd_iwrite(8'h32, 8'h77);
        cmd_write(16'hFE00, 8'h00, 1'b1);
    endtask

    task automatic t_readsp();
        xfer(8'h0C);
        get_resp(sp_in[15:8], "R11 stack pointer high");
        get_resp(sp_in[7:0], "R11 stack pointer low");
    endtask

    task automatic t_run();
        int r0 = run_cnt;
        xfer(8'h28);
        repeat (6) @(negedge clk);
        chk(run_cnt == r0 + 1, "R12 single run pulse", run_cnt - r0, 1);
        cmd_read(16'h0010, mem[8'h10], "R12 engine idle after run");
    endtask

    task automatic t_unlocked();
        cmd_read(16'hC020, mem[8'h20], "R6 protected read after unlock");
        cmd_iread(mem[8'h21], mem[8'h22], "R6 R9 protected indexed read after unlock");
    endtask

    initial begin
        logic [7:0] good [6];
        logic [7:0] bad  [6];
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        for (int i = 0; i < 6; i++) begin
            good[i] = 8'h11 * 8'(i + 1);
            mem[8'hF8 + i] = good[i];
            bad[i] = good[i];
        end
        bad[5] = 8'h67;
        mem[8'h20] = 8'h5A;
        do_reset();
        t_reset();
        t_key(bad, 1'b0);
        t_locked();
        t_readsp();
        t_run();
        do_reset();
        t_key(good, 1'b1);
        t_unlocked();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule